// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block sits between a clocked system port and one external asynchronous static RAM of 8K x 8. The system side offers single accesses through a valid/ready handshake: a 13-bit address, a direction bit and 8 bits of write data. A read returns its byte with a one-cycle valid pulse. The memory side drives the address, two chip selects of opposite polarity, an active-low write strobe, an active-low output enable and a drive enable for the shared data bus.

Every analog timing limit of the RAM is a parameter in nanoseconds. Each limit is turned into a whole number of clock cycles by rounding up, with a floor of one cycle. Each access is then played out as a short fixed sequence of phases, and each phase holds for a counted number of cycles. While the supply-good input is low, the controller parks the RAM in its retention-safe standby state. After supply-good rises, it waits one full cycle time before it accepts the first request.

Top module: `sram_ctrl`

## Requirements
- R1: While rst_ni is low, or in the cycle after any edge that samples pwr_good_i low, the pins are: mem_ce_o=0, mem_ce_n_o=1, mem_we_n_o=1, mem_oe_n_o=1, mem_dq_oe_o=0 and req_ready_o=0.
- R2: After the first edge that samples pwr_good_i high, req_ready_o stays low for ceil(T_RC_NS/CLK_NS) cycles. With the defaults it first reads 1 after the 16th such edge.
- R3: Whenever req_ready_o is 1, the RAM is deselected: mem_ce_n_o=1 and mem_ce_o=0.
- R4: A read accepted at an edge holds the following for ceil(max(T_AA,T_OE,T_RC)/CLK) cycles (15 with the defaults): mem_addr_o at the request address, mem_ce_n_o=0, mem_ce_o=1, mem_oe_n_o=0, mem_we_n_o=1 and mem_dq_oe_o=0.
- R5: The read byte is mem_dq_i as sampled on the edge that ends the R4 window. rsp_valid_o is 1 for exactly one cycle after that edge, and rsp_rdata_o carries the byte.
- R6: After a read, req_ready_o stays low and mem_dq_oe_o stays 0 for ceil(T_HZ_NS/CLK) cycles (5) from the cycle in which mem_oe_n_o returns high. A write issued at once therefore first drives the bus 6 cycles after that cycle.
- R7: A write holds mem_we_n_o low for ceil(max(T_WP,T_DS)/CLK) cycles (9). During this time mem_oe_n_o=1, mem_dq_oe_o=1, mem_dq_o holds the write data and mem_addr_o holds the request address.
- R8: After mem_we_n_o rises, the address, the data drive and the chip selects stay unchanged for max(ceil(T_WR/CLK), ceil(T_DH/CLK), C_WC-C_WP) cycles (6). Then req_ready_o returns to 1.
- R9: req_ready_o falls in the cycle after an acceptance. A request presented while req_ready_o is 0 is not taken and leaves the memory contents unchanged.
- R10: If pwr_good_i falls during an access, the access is abandoned and the pins take the R1 standby state in the next cycle.
- R11: mem_dq_oe_o is never 1 in a cycle where mem_oe_n_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_good_i | input | 1 | Supply stable; low forces standby |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller can accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Request address |
| req_wdata_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | One-cycle read data strobe |
| rsp_rdata_o | output | DATA_W | Read data |
| mem_addr_o | output | ADDR_W | RAM address |
| mem_ce_n_o | output | 1 | RAM select, active low |
| mem_ce_o | output | 1 | RAM select, active high (low in standby) |
| mem_we_n_o | output | 1 | RAM write strobe, active low |
| mem_oe_n_o | output | 1 | RAM output enable, active low |
| mem_dq_o | output | DATA_W | Data driven toward the RAM |
| mem_dq_oe_o | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | DATA_W | Data returned from the RAM |

## Verification
The assertions check the pin rules that must hold on every cycle. These are: the standby pin state after supply loss, deselection whenever ready is high, output enable held high while the write strobe is low, no bus drive while the RAM may still be driving, the minimum supply-good wait, address stability after the write strobe rises, and the single-cycle response pulse. The exact phase lengths, the byte captured at the end of the read window, the write-to-read data path through a model RAM that returns garbage until its access time has elapsed, the dropping of requests made while busy and the abort part-way through a write can only be shown by the bench's scenarios.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_WAKE,
    ST_IDLE,
    ST_READ,
    ST_TURN,
    ST_WPULSE,
    ST_WREC
  } state_e;

  // ns to whole cycles, rounded up, never below one
  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned C_PU  = 15,
  parameter int unsigned C_RD  = 15,
  parameter int unsigned C_HZ  = 5,
  parameter int unsigned C_WP  = 9,
  parameter int unsigned C_REC = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_good_i,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic             done_i,
  output state_e           state_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             accept_o,
  output logic             capture_o
);

  state_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    accept_o  = 1'b0;
    capture_o = 1'b0;
    if (!pwr_good_i) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:    state_d = ST_WAKE;
        ST_WAKE:   if (done_i) state_d = ST_IDLE;
        ST_IDLE:   if (req_valid_i) begin
                     accept_o = 1'b1;
                     state_d  = req_write_i ? ST_WPULSE : ST_READ;
                   end
        ST_READ:   if (done_i) begin
                     capture_o = 1'b1;
                     state_d   = ST_TURN;
                   end
        ST_TURN:   if (done_i) state_d = ST_IDLE;
        ST_WPULSE: if (done_i) state_d = ST_WREC;
        ST_WREC:   if (done_i) state_d = ST_IDLE;
        default:   state_d = ST_OFF;
      endcase
    end
  end

  // each phase lasts N cycles: load N-1 on entry
  always_comb begin
    unique case (state_d)
      ST_WAKE:   load_val_o = CNT_W'(C_PU - 1);
      ST_READ:   load_val_o = CNT_W'(C_RD - 1);
      ST_TURN:   load_val_o = CNT_W'(C_HZ - 1);
      ST_WPULSE: load_val_o = CNT_W'(C_WP - 1);
      ST_WREC:   load_val_o = CNT_W'(C_REC - 1);
      default:   load_val_o = '0;
    endcase
  end

  assign load_o = (state_d != state_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OFF;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

endmodule

// File: rtl/sram_ctrl_dp.sv
module sram_ctrl_dp
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  state_e            state_i,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_n_o,
  output logic              mem_ce_o,
  output logic              mem_we_n_o,
  output logic              mem_oe_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;
  logic              sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= capture_i;
      if (capture_i) rdata_q <= mem_dq_i;
    end
  end

  // pins decoded from the registered state only
  assign sel         = (state_i == ST_READ) || (state_i == ST_WPULSE) || (state_i == ST_WREC);
  assign mem_ce_n_o  = ~sel;
  assign mem_ce_o    = sel;
  assign mem_oe_n_o  = ~(state_i == ST_READ);
  assign mem_we_n_o  = ~(state_i == ST_WPULSE);
  assign mem_dq_oe_o = (state_i == ST_WPULSE) || (state_i == ST_WREC);
  assign mem_addr_o  = addr_q;
  assign mem_dq_o    = wdata_q;
  assign req_ready_o = (state_i == ST_IDLE);
  assign rsp_valid_o = rvalid_q;
  assign rsp_rdata_o = rdata_q;

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 13,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CLK_NS  = 10,
  parameter int unsigned T_RC_NS = 150,
  parameter int unsigned T_AA_NS = 150,
  parameter int unsigned T_OE_NS = 70,
  parameter int unsigned T_WC_NS = 150,
  parameter int unsigned T_WP_NS = 90,
  parameter int unsigned T_DS_NS = 60,
  parameter int unsigned T_DH_NS = 10,
  parameter int unsigned T_WR_NS = 10,
  parameter int unsigned T_HZ_NS = 50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_good_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_n_o,
  output logic              mem_ce_o,
  output logic              mem_we_n_o,
  output logic              mem_oe_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int unsigned C_PU  = ns2cyc(T_RC_NS, CLK_NS);
  localparam int unsigned C_RD  = max2(max2(ns2cyc(T_AA_NS, CLK_NS), ns2cyc(T_OE_NS, CLK_NS)),
                                       ns2cyc(T_RC_NS, CLK_NS));
  localparam int unsigned C_HZ  = ns2cyc(T_HZ_NS, CLK_NS);
  localparam int unsigned C_WP  = max2(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_DS_NS, CLK_NS));
  localparam int unsigned C_WC  = ns2cyc(T_WC_NS, CLK_NS);
  localparam int unsigned C_PAD = (C_WC > C_WP) ? (C_WC - C_WP) : 1;
  localparam int unsigned C_REC = max2(max2(ns2cyc(T_WR_NS, CLK_NS), ns2cyc(T_DH_NS, CLK_NS)), C_PAD);
  localparam int unsigned C_MAX = max2(max2(max2(C_PU, C_RD), max2(C_HZ, C_WP)), C_REC);
  localparam int unsigned CNT_W = (C_MAX > 1) ? $clog2(C_MAX) : 1;

  state_e           state;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             done;
  logic             accept;
  logic             capture;

  sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .done_o     (done)
  );

  sram_ctrl_seq #(
    .CNT_W (CNT_W),
    .C_PU  (C_PU),
    .C_RD  (C_RD),
    .C_HZ  (C_HZ),
    .C_WP  (C_WP),
    .C_REC (C_REC)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pwr_good_i  (pwr_good_i),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .done_i      (done),
    .state_o     (state),
    .load_o      (load),
    .load_val_o  (load_val),
    .accept_o    (accept),
    .capture_o   (capture)
  );

  sram_ctrl_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_i     (state),
    .accept_i    (accept),
    .capture_i   (capture),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .mem_dq_i    (mem_dq_i),
    .req_ready_o (req_ready_o),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ce_n_o  (mem_ce_n_o),
    .mem_ce_o    (mem_ce_o),
    .mem_we_n_o  (mem_we_n_o),
    .mem_oe_n_o  (mem_oe_n_o),
    .mem_dq_o    (mem_dq_o),
    .mem_dq_oe_o (mem_dq_oe_o)
  );

endmodule

// File: rtl/sram_ctrl_sva.sv
module sram_ctrl_sva
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 13,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CLK_NS  = 10,
  parameter int unsigned T_RC_NS = 150,
  parameter int unsigned T_HZ_NS = 50
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pwr_good_i,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ce_n_o,
  input logic              mem_ce_o,
  input logic              mem_we_n_o,
  input logic              mem_oe_n_o,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe_o
);

  localparam int unsigned K_PU = ns2cyc(T_RC_NS, CLK_NS);
  localparam int unsigned K_HZ = ns2cyc(T_HZ_NS, CLK_NS);

  int unsigned since_oe;
  int unsigned since_pg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              since_oe <= K_HZ;
    else if (!mem_oe_n_o)     since_oe <= 0;
    else if (since_oe < K_HZ) since_oe <= since_oe + 1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               since_pg <= 0;
    else if (!pwr_good_i)      since_pg <= 0;
    else if (since_pg <= K_PU) since_pg <= since_pg + 1;
  end

  // R1, R10
  a_r10_standby_on_power_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> (!mem_ce_o && mem_ce_n_o && mem_we_n_o && mem_oe_n_o && !mem_dq_oe_o && !req_ready_o));

  a_r2_wake_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (since_pg > K_PU));

  a_r3_idle_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (mem_ce_n_o && !mem_ce_o));

  a_r4_read_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_n_o |-> (!mem_ce_n_o && mem_ce_o && mem_we_n_o));

  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  a_r6_turnaround: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> (since_oe >= K_HZ));

  a_r7_oe_off_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> (mem_oe_n_o && mem_dq_oe_o));

  a_r8_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_good_i && $rose(mem_we_n_o)) |=> $stable(mem_addr_o) && $stable(mem_dq_o));

  a_r9_ready_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_good_i && req_valid_i && req_ready_o) |=> !req_ready_o);

  a_r11_no_contention: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_dq_oe_o && !mem_oe_n_o));

endmodule

bind sram_ctrl sram_ctrl_sva #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .CLK_NS  (CLK_NS),
  .T_RC_NS (T_RC_NS),
  .T_HZ_NS (T_HZ_NS)
) u_sva (.*);

// File: tb/sram_ctrl_test.sv
module sram_ctrl_test;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        pwr_good_i;
  logic        req_valid_i;
  logic        req_ready_o;
  logic        req_write_i;
  logic [12:0] req_addr_i;
  logic [7:0]  req_wdata_i;
  logic        rsp_valid_o;
  logic [7:0]  rsp_rdata_o;
  logic [12:0] mem_addr_o;
  logic        mem_ce_n_o, mem_ce_o, mem_we_n_o, mem_oe_n_o, mem_dq_oe_o;
  logic [7:0]  mem_dq_o;
  logic [7:0]  mem_dq_i;

  sram_ctrl uut (.*);

  always #5 clk_i = ~clk_i;

  // RAM model: 64 bytes keyed by address[5:0]; garbage until 14 edges of stable read
  logic [7:0] model [64];
  int         rd_cnt;
  logic       rd_cond;
  assign rd_cond  = !mem_ce_n_o && mem_ce_o && !mem_oe_n_o && mem_we_n_o;
  assign mem_dq_i = (rd_cond && rd_cnt >= 14) ? model[mem_addr_o[5:0]] : 8'hEE;

  initial for (int i = 0; i < 64; i++) model[i] = 8'h00;

  always @(posedge clk_i) rd_cnt <= rd_cond ? rd_cnt + 1 : 0;

  always @(posedge mem_we_n_o)
    if (!mem_ce_n_o && mem_ce_o && mem_dq_oe_o) model[mem_addr_o[5:0]] <= mem_dq_o;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;
  int t_oe_rise = -100;
  logic prev_read = 1'b0;

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
    $finish;
  end

  task automatic tick();
    @(posedge clk_i);
    #1;
    cyc++;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit standby_pins();
    return !mem_ce_o && mem_ce_n_o && mem_we_n_o && mem_oe_n_o && !mem_dq_oe_o;
  endfunction

  task automatic access(input logic w, input logic [12:0] a, input logic [7:0] d);
    int n;
    bit bad;
    n = 0;
    while (!req_ready_o && n < 200) begin tick(); n++; end
    req_valid_i = 1'b1; req_write_i = w; req_addr_i = a; req_wdata_i = d;
    tick();
    req_valid_i = 1'b0;
    chk(!req_ready_o, "R9 ready drop", int'(req_ready_o), 0);
    if (w) begin
      if (prev_read) chk((cyc - t_oe_rise) == 6, "R6 write after read", cyc - t_oe_rise, 6);
      n = 0; bad = 0;
      while (!mem_we_n_o && n < 100) begin
        if (!mem_oe_n_o || !mem_dq_oe_o || mem_dq_o != d || mem_addr_o != a) bad = 1;
        n++; tick();
      end
      chk(n == 9, "R7 strobe length", n, 9);
      chk(!bad, "R7 pins during strobe", int'(bad), 0);
      n = 0; bad = 0;
      while (!req_ready_o && n < 100) begin
        if (mem_ce_n_o || !mem_ce_o || !mem_dq_oe_o || mem_dq_o != d || mem_addr_o != a) bad = 1;
        n++; tick();
      end
      chk(n == 6, "R8 recovery length", n, 6);
      chk(!bad, "R8 hold after strobe", int'(bad), 0);
      prev_read = 1'b0;
    end else begin
      n = 0; bad = 0;
      while (!mem_oe_n_o && n < 100) begin
        if (mem_ce_n_o || !mem_ce_o || !mem_we_n_o || mem_dq_oe_o || mem_addr_o != a) bad = 1;
        n++; tick();
      end
      chk(n == 15, "R4 read window", n, 15);
      chk(!bad, "R4 read pins", int'(bad), 0);
      chk(rsp_valid_o && rsp_rdata_o == d, "R5 read data", int'(rsp_rdata_o), int'(d));
      t_oe_rise = cyc;
      tick();
      chk(!rsp_valid_o, "R5 pulse width", int'(rsp_valid_o), 0);
      n = 1; bad = 0;
      while (!req_ready_o && n < 100) begin
        if (mem_dq_oe_o || !standby_pins()) bad = 1;
        n++; tick();
      end
      chk(n == 5, "R6 turnaround length", n, 5);
      chk(!bad, "R6 bus released", int'(bad), 0);
      chk(mem_ce_n_o && !mem_ce_o, "R3 idle deselect", int'(mem_ce_o), 0);
      prev_read = 1'b1;
    end
  endtask

  // {write, addr, data}; read entries carry expected data
  localparam logic [21:0] VEC [10] = '{
    {1'b1, 13'h0005, 8'hA5},
    {1'b1, 13'h1FFF, 8'h3C},
    {1'b1, 13'h0A12, 8'hFF},
    {1'b1, 13'h1000, 8'h00},
    {1'b0, 13'h0005, 8'hA5},
    {1'b0, 13'h1FFF, 8'h3C},
    {1'b1, 13'h0005, 8'h5A},
    {1'b0, 13'h0005, 8'h5A},
    {1'b0, 13'h0A12, 8'hFF},
    {1'b0, 13'h1000, 8'h00}
  };

  initial begin
    int n;
    bit bad;
    rst_ni = 1'b0; pwr_good_i = 1'b0; req_valid_i = 1'b0;
    req_write_i = 1'b0; req_addr_i = '0; req_wdata_i = '0;
    repeat (3) tick();
    chk(standby_pins() && !req_ready_o, "R1 reset pins", int'(mem_ce_o), 0);
    rst_ni = 1'b1;
    repeat (3) tick();
    chk(standby_pins() && !req_ready_o, "R1 no supply", int'(req_ready_o), 0);

    // R2: count edges until ready
    pwr_good_i = 1'b1;
    n = 0; bad = 0;
    while (!req_ready_o && n < 100) begin
      tick(); n++;
      if (mem_ce_o) bad = 1;
    end
    chk(n == 16, "R2 wake delay", n, 16);
    chk(!bad, "R1 ce low while waking", int'(bad), 0);
    chk(mem_ce_n_o && !mem_ce_o, "R3 idle deselect", int'(mem_ce_o), 0);

    for (int i = 0; i < 10; i++) access(VEC[i][21], VEC[i][20:8], VEC[i][7:0]);

    // R9: a write presented while busy with a read is dropped
    req_valid_i = 1'b1; req_write_i = 1'b0; req_addr_i = 13'h0005;
    tick();
    req_write_i = 1'b1; req_wdata_i = 8'h77;
    n = 0;
    for (int k = 0; k < 10; k++) begin
      if (req_ready_o) n++;
      tick();
    end
    req_valid_i = 1'b0;
    chk(n == 0, "R9 busy ready", n, 0);
    prev_read = 1'b0;
    access(1'b0, 13'h0005, 8'h5A);
    chk(1'b1, "R9 ignored write left byte", 0, 0);

    // R10: supply loss in the middle of a write
    while (!req_ready_o) tick();
    req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = 13'h0A12; req_wdata_i = 8'h11;
    tick();
    req_valid_i = 1'b0;
    repeat (3) tick();
    chk(!mem_we_n_o, "R10 write in progress", int'(mem_we_n_o), 0);
    pwr_good_i = 1'b0;
    tick();
    chk(standby_pins() && !req_ready_o, "R10 abort to standby", int'(mem_ce_o), 0);
    tick();
    pwr_good_i = 1'b1;
    n = 0;
    while (!req_ready_o && n < 100) begin tick(); n++; end
    chk(n == 16, "R2 wake after loss", n, 16);
    access(1'b0, 13'h0A12, 8'hFF);

    report();
    $finish;
  end

endmodule